// File: doc/BRIEF.md
# Parameterizable Serial Transmitter

This block turns a parallel data word into an asynchronous serial frame on a single output line. The data width, the number of trailing stop bits and the bit order are fixed when the block is built. Everything runs on one system clock. A separate baud-enable input pulses high for one clock cycle at each bit boundary, and this pulse acts only as a clock enable. The baud divider that makes the pulse is outside the block.

To send a word, the user presents it on the data input and pulses the load strobe while the block is idle. The block captures the word and raises its busy flag in the same clock edge. It then sends a low start bit, the data bits and the configured run of high stop bits, moving by one bit on each baud-enable pulse. A load strobe that arrives while a frame is in progress is dropped silently. Busy stays high until the last stop bit has lasted a full bit period.

Reset is asynchronous and active low. Its release is assumed to be synchronous to the clock. Reset returns the block to idle, with the line high and busy low.

Top module: `sertx_top`

## Requirements
- R1: While reset is low, and on the first cycle after it, the line output is 1 and busy is 0. Asserting reset in the middle of a frame abandons that frame at once.
- R2: A load strobe sampled while busy is 0 captures the data word, and busy reads 1 after that same clock edge.
- R3: A load strobe sampled while busy is 1 is ignored. The frame in progress keeps its original bits, and no extra frame follows it.
- R4: The start bit (line 0) begins at the first baud-enable pulse after the edge that accepted the load. A pulse sampled at that same edge does not start it.
- R5: The data bits follow the start bit, one per baud-enable period. With MSB_FIRST=1 (the default) bit DATA_W-1 is sent first. With MSB_FIRST=0 bit 0 is sent first.
- R6: STOP_CNT stop bits at level 1 follow the data. Busy stays 1 through all of them and falls at the baud-enable pulse that ends the last one.
- R7: The line output changes only at a clock edge where baud-enable is sampled high.
- R8: While busy is 0 the line output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle baud-enable pulse, one per bit period |
| load_i | input | 1 | Load strobe; accepted only while idle |
| data_i | input | DATA_W | Parallel word to send |
| line_o | output | 1 | Serial output, idles high |
| busy_o | output | 1 | High from accepted load until frame end |

## Verification
Assertions check four rules on every cycle: the line holds between baud-enable pulses, the line is high whenever the block is idle, a load while busy never reaches the capture path, and busy rises after an accepted load. Only the bench's scenarios can show that whole frames are correct. That covers the bit order for each setting, the exact length of a seven-stop-bit tail, the one-pulse delay of the start bit when the load coincides with a baud pulse, and the absence of a second frame after a dropped load. The bench covers these on two builds, an 8-bit MSB-first build with two stop bits and a 5-bit LSB-first build with seven stop bits.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ARMED = 3'd1,
    PH_START = 3'd2,
    PH_DATA  = 3'd3,
    PH_STOP  = 3'd4
  } phase_t;
endpackage

// File: rtl/sertx_shreg.sv
module sertx_shreg #(
  parameter int DATA_W    = 8,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bit_o
);
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_d;
  logic [DATA_W-1:0] word_shifted;

  generate
    if (MSB_FIRST) begin : g_msb
      assign word_shifted = {word_q[DATA_W-2:0], 1'b0};
      assign bit_o        = word_q[DATA_W-1];
    end else begin : g_lsb
      assign word_shifted = {1'b0, word_q[DATA_W-1:1]};
      assign bit_o        = word_q[0];
    end
  endgenerate

  always_comb begin
    word_d = word_q;
    if (cap_i)        word_d = data_i;
    else if (shift_i) word_d = word_shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  // R3: without capture or shift the presented bit must not move
  p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_i && !shift_i) |=> $stable(bit_o));
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int STOP_CNT = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bit_tick,
  input  logic   load_i,
  output phase_t phase_o,
  output logic   cap_o,
  output logic   shift_o,
  output logic   busy_o
);
  localparam int MAXC = (DATA_W > STOP_CNT) ? DATA_W : STOP_CNT;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LAST_D = CW'(DATA_W - 1);
  localparam logic [CW-1:0] LAST_S = CW'(STOP_CNT - 1);

  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    cap_o   = 1'b0;
    shift_o = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (load_i) begin
          ph_d  = PH_ARMED;
          cap_o = 1'b1;
        end
      end
      PH_ARMED: begin
        if (bit_tick) ph_d = PH_START;
      end
      PH_START: begin
        if (bit_tick) begin
          ph_d  = PH_DATA;
          cnt_d = '0;
        end
      end
      PH_DATA: begin
        if (bit_tick) begin
          shift_o = 1'b1;
          if (cnt_q == LAST_D) begin
            ph_d  = PH_STOP;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PH_STOP: begin
        if (bit_tick) begin
          if (cnt_q == LAST_S) ph_d = PH_IDLE;
          else                 cnt_d = cnt_q + 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase_o = ph_q;
  assign busy_o  = (ph_q != PH_IDLE);

  // R5: data bit index stays inside the word
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DATA) |-> (cnt_q <= LAST_D));
  // R6: stop-bit count stays inside the configured tail
  p_stop_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_STOP) |-> (cnt_q <= LAST_S));
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STOP_CNT  = 2,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              line_o,
  output logic              busy_o
);
  phase_t phase;
  logic   cap;
  logic   shift;
  logic   data_bit;

  sertx_ctrl #(
    .DATA_W   (DATA_W),
    .STOP_CNT (STOP_CNT)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .load_i   (load_i),
    .phase_o  (phase),
    .cap_o    (cap),
    .shift_o  (shift),
    .busy_o   (busy_o)
  );

  sertx_shreg #(
    .DATA_W    (DATA_W),
    .MSB_FIRST (MSB_FIRST)
  ) u_shreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_i   (cap),
    .shift_i (shift),
    .data_i  (data_i),
    .bit_o   (data_bit)
  );

  always_comb begin
    case (phase)
      PH_START: line_o = 1'b0;
      PH_DATA:  line_o = data_bit;
      default:  line_o = 1'b1;
    endcase
  end

  // R2: an accepted load raises busy at that edge
  p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !busy_o) |=> busy_o);
  // R3: a load seen while busy never reaches the capture path
  p_drop_when_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && busy_o) |-> !cap);
  // R7: line holds across edges without a baud pulse
  p_hold_between_ticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(line_o));
  // R8: idle line is high
  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> line_o);
endmodule

// File: tb/sim_sertx_top.sv
`timescale 1ns/1ps
module sim_sertx_top;
  localparam int W0 = 8, S0 = 2;
  localparam int W1 = 5, S1 = 7;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  int   tick_cnt = 0;
  logic load0 = 1'b0, load1 = 1'b0;
  logic [W0-1:0] data0 = '0;
  logic [W1-1:0] data1 = '0;
  logic line0, busy0, line1, busy1;

  int n_total = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
    tick     <= (tick_cnt == TICK_DIV - 1);
  end

  sertx_top #(.DATA_W(W0), .STOP_CNT(S0), .MSB_FIRST(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(tick), .load_i(load0),
    .data_i(data0), .line_o(line0), .busy_o(busy0));

  sertx_top #(.DATA_W(W1), .STOP_CNT(S1), .MSB_FIRST(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .bit_tick(tick), .load_i(load1),
    .data_i(data1), .line_o(line1), .busy_o(busy1));

  // bit 8: issue a load during the data bits; bits 7:0: word
  localparam logic [8:0] VEC [6] = '{
    9'h0A5, 9'h13C, 9'h001, 9'h180, 9'h0FF, 9'h15A
  };

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic to_tick();
    while (!tick) step();
    step();
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic line_of(input int sel);
    return (sel == 0) ? line0 : line1;
  endfunction
  function automatic logic busy_of(input int sel);
    return (sel == 0) ? busy0 : busy1;
  endfunction

  task automatic run_frame(input int sel, input logic [7:0] word, input bit intrude);
    int w = (sel == 0) ? W0 : W1;
    int s = (sel == 0) ? S0 : S1;
    logic prev;
    logic expb;
    if (sel == 0) begin data0 = word; load0 = 1'b1; end
    else begin data1 = word[W1-1:0]; load1 = 1'b1; end
    step();
    load0 = 1'b0; load1 = 1'b0;
    data0 = ~data0; data1 = ~data1;
    check("R2", "busy after load", busy_of(sel), 1);
    check("R4", "line before start", line_of(sel), 1);
    to_tick();
    check("R4", "start bit", line_of(sel), 0);
    for (int i = 0; i < w; i++) begin
      to_tick();
      expb = (sel == 0) ? word[W0-1-i] : word[i];
      check("R5", $sformatf("u%0d data bit %0d", sel, i), line_of(sel), expb);
      prev = line_of(sel);
      if (intrude && i == 1) begin
        if (sel == 0) load0 = 1'b1; else load1 = 1'b1;
        step();
        load0 = 1'b0; load1 = 1'b0;
        check("R3", "busy held on dropped load", busy_of(sel), 1);
      end else begin
        step();
      end
      check("R7", "line held between ticks", line_of(sel), prev);
    end
    for (int k = 0; k < s; k++) begin
      to_tick();
      check("R6", $sformatf("u%0d stop bit %0d level", sel, k), line_of(sel), 1);
      check("R6", "busy during stop", busy_of(sel), 1);
    end
    to_tick();
    check("R6", "busy clears after last stop", busy_of(sel), 0);
    for (int k = 0; k < 2; k++) begin
      to_tick();
      check("R3", "no extra frame (busy)", busy_of(sel), 0);
      check("R8", "idle line high", line_of(sel), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    int guard;
    step();
    check("R1", "u0 line in reset", line0, 1);
    check("R1", "u0 busy in reset", busy0, 0);
    check("R1", "u1 busy in reset", busy1, 0);
    rst_n = 1'b1;
    step();
    check("R1", "u0 line after reset", line0, 1);
    check("R1", "u1 line after reset", line1, 1);

    for (int v = 0; v < 6; v++) begin
      run_frame(0, VEC[v][7:0], VEC[v][8]);
      run_frame(1, VEC[v][7:0], VEC[v][8]);
    end

    // R4: a load that coincides with a baud pulse waits for the next pulse
    while (!tick) step();
    data0 = 8'hC3;
    load0 = 1'b1;
    step();
    load0 = 1'b0;
    check("R4", "coincident load: busy", busy0, 1);
    check("R4", "coincident load: line still high", line0, 1);
    to_tick();
    check("R4", "coincident load: start bit", line0, 0);
    to_tick();
    check("R5", "coincident load: first bit msb", line0, 1);
    guard = 0;
    while (busy0 && guard < 100) begin step(); guard++; end
    check("R6", "frame ends", busy0, 0);

    // R1: reset in the middle of a frame
    data0 = 8'h00;
    load0 = 1'b1;
    step();
    load0 = 1'b0;
    to_tick();
    check("R1", "mid-frame start bit", line0, 0);
    rst_n = 1'b0;
    #1;
    check("R1", "mid-frame reset line", line0, 1);
    check("R1", "mid-frame reset busy", busy0, 0);
    step();
    rst_n = 1'b1;
    to_tick();
    check("R1", "no resume after reset", line0, 1);
    check("R8", "idle after reset", busy0, 0);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule